// File: doc/BRIEF.md
# Clear-to-Send Transmit Gate and Modem Status Interrupt

This block sits beside a UART transmitter and decides when the transmitter may begin its next byte. When flow control on the clear-to-send line is switched on, a byte may only start while that line is active (low). The line is sampled at the middle of the stop bit being sent: if it is inactive at that point, the following byte is held back; if it is active at that point, the following byte goes even if the line drops afterwards. With flow control off, bytes start as soon as the transmitter is idle and has data.

The block also watches the four modem lines (clear-to-send, data-carrier-detect, data-set-ready, ring indicator). Each goes through a two-flop synchronizer. A change on any of the first three lines sets its own change flag. The ring flag is set only at the end of a ring, when the pin goes from low to high. All flags clear together on a status-read strobe. A single interrupt line is raised from the flags according to three enables: the master modem-status enable, the flow-control enable and a separate enable for clear-to-send interrupts.

Top module: `modem_cts_ctl`

## Requirements
- R1: After reset all four change flags are 0, `irq` is 0, and `start_grant` is 0 while `byte_ready` is 0.
- R2: With `auto_cts_en`=0, `start_grant` is 1 whenever `tx_phase`=0 (idle) and `byte_ready`=1, whatever the level of `cts_in`.
- R3: With `auto_cts_en`=1, an idle transmitter with data is granted only when the synchronized `cts_in` is low. A pin change reaches the synchronized level after two clock edges.
- R4: With `auto_cts_en`=1, `cts_in` is sampled in each cycle with `tx_phase`=2 (middle of the stop bit). A low sample allows the next byte to start even if the pin has since gone high. A high sample blocks it until the synchronized pin is low again.
- R5: Any change of `cts_in` sets `d_cts` three clock edges after the pin changes, with `auto_cts_en` either 0 or 1.
- R6: A change of `dcd_in` sets `d_dcd` and a change of `dsr_in` sets `d_dsr`. `ri_end` is set by a low-to-high transition of `ri_in` and not by a high-to-low one.
- R7: A one-cycle `status_rd` clears all four flags at the next edge, and `irq` then drops.
- R8: With `msi_en`=0, `irq` is 0 whatever the flags hold.
- R9: With `msi_en`=1 and `auto_cts_en`=0, `irq` is 1 if any of the four flags is set.
- R10: With `msi_en`=1, `auto_cts_en`=1 and `cts_irq_en`=0, `d_cts` alone does not raise `irq`. `d_dcd`, `d_dsr` or `ri_end` still do.
- R11: With `msi_en`=1, `auto_cts_en`=1 and `cts_irq_en`=1, `d_cts` raises `irq`.
- R12: `start_grant` is never 1 while `tx_phase` is not 0 (idle). Encoding of `tx_phase`: 0 idle, 1 sending, 2 middle of the stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cts_in | input | 1 | Clear-to-send pin, low = active |
| dcd_in | input | 1 | Data-carrier-detect pin |
| dsr_in | input | 1 | Data-set-ready pin |
| ri_in | input | 1 | Ring-indicator pin, low = ringing |
| auto_cts_en | input | 1 | Gate byte starts on clear-to-send |
| msi_en | input | 1 | Master modem-status interrupt enable |
| cts_irq_en | input | 1 | Lets clear-to-send changes interrupt while gating is on |
| tx_phase | input | 2 | Transmitter phase: 0 idle, 1 sending, 2 mid stop bit |
| byte_ready | input | 1 | Transmitter holds a byte to send |
| status_rd | input | 1 | Status-read strobe, clears all flags |
| start_grant | output | 1 | Next byte may start this cycle |
| d_cts | output | 1 | Clear-to-send changed |
| d_dcd | output | 1 | Carrier-detect changed |
| d_dsr | output | 1 | Data-set-ready changed |
| ri_end | output | 1 | Ring ended (pin low to high) |
| irq | output | 1 | Modem status interrupt |

## Verification
The hardest case to reach is the race at the stop bit. The pin has to change after the mid-stop sample but before the synchronized level catches up, so that the latched decision and the live level disagree when the transmitter returns to idle. The stimulus holds the line steady, pulses the mid-stop phase for one cycle, then flips the pin and goes idle with data at once. It samples the grant within the two cycles the synchronizer lags, and again after the lag has passed.

// File: rtl/modem_pkg.sv
// Shared types for the modem control block.
// Assumes the transmitter reports its phase with the encoding below.
package modem_pkg;
    typedef enum logic [1:0] {
        TXP_IDLE    = 2'd0,
        TXP_SEND    = 2'd1,
        TXP_MIDSTOP = 2'd2
    } tx_phase_e;

    localparam int MODEM_LINES = 4;
    localparam int IDX_CTS = 0;
    localparam int IDX_DCD = 1;
    localparam int IDX_DSR = 2;
    localparam int IDX_RI  = 3;
endpackage

// File: rtl/modem_sync.sv
// Multi-stage synchronizer for asynchronous modem pins.
// Assumes pins idle high; every stage resets to RESET_VAL.
module modem_sync #(
    parameter int              WIDTH     = 4,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift the pin value one stage further along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n)      chain[s] <= RESET_VAL;
                else if (s == 0) chain[s] <= d_async;
                else             chain[s] <= chain[(s > 0) ? s-1 : 0];
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/modem_delta.sv
// Change detector with sticky flags and clear-on-read.
// Lines other than RI_IDX flag on any change. RI_IDX flags only on a
// low-to-high transition. A new event in the same cycle as a read wins.
module modem_delta #(
    parameter int WIDTH  = 4,
    parameter int RI_IDX = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    input  logic             status_rd,
    output logic [WIDTH-1:0] flags
);
    logic [WIDTH-1:0] prev;
    logic [WIDTH-1:0] ev;

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '1;
        else        prev <= lvl;
    end

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_line
            if (i == RI_IDX) begin : g_rise
                // Only the end of a ring (low to high) counts.
                assign ev[i] = ~prev[i] & lvl[i];
            end else begin : g_any
                // Either direction counts.
                assign ev[i] = prev[i] ^ lvl[i];
            end

            // Sticky flag: set by an event, cleared by a read.
            always_ff @(posedge clk) begin
                if (!rst_n) flags[i] <= 1'b0;
                else        flags[i] <= (flags[i] & ~status_rd) | ev[i];
            end

            // R5, R6: an observed change is flagged on the next edge.
            assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
                ev[i] |=> flags[i]);
            // R7: a read with no new event leaves the flag clear.
            assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (status_rd && !ev[i]) |=> !flags[i]);
        end
    endgenerate

    // R6: a falling ring pin never sets the ring flag by itself.
    assert_ri_fall_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags[RI_IDX] && !(~prev[RI_IDX] & lvl[RI_IDX])) |=> !flags[RI_IDX]);
endmodule

// File: rtl/cts_gate.sv
// Grants the start of the next transmit byte.
// With gating on, the grant uses the latched mid-stop sample or the live
// synchronized level. Assumes the transmitter leaves idle the cycle after
// a grant, and that cts_lvl is already synchronized (low = clear).
module cts_gate
    import modem_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cts_lvl,
    input  logic      auto_en,
    input  tx_phase_e phase,
    input  logic      byte_ready,
    output logic      grant
);
    logic mid_ok;
    logic cts_act;
    logic is_idle;

    assign cts_act = ~cts_lvl;
    assign is_idle = (phase == TXP_IDLE);

    // Latch the clear-to-send decision at the middle of the stop bit and
    // drop it once used or once the idle transmitter has nothing to send.
    always_ff @(posedge clk) begin
        if (!rst_n)                                mid_ok <= 1'b0;
        else if (phase == TXP_MIDSTOP)             mid_ok <= cts_act;
        else if (is_idle && (!byte_ready || grant)) mid_ok <= 1'b0;
    end

    // Start permission: idle with data, and clear-to-send if gating is on.
    always_comb begin
        grant = is_idle && byte_ready && (!auto_en || mid_ok || cts_act);
    end

    // R12: no grant outside idle.
    assert_grant_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (phase == TXP_IDLE));
    // R4: a blocked mid-stop sample holds back the byte while the pin stays high.
    assert_midstop_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == TXP_MIDSTOP && cts_lvl && auto_en) |=> !(grant && cts_lvl && auto_en));
endmodule

// File: rtl/modem_cts_ctl.sv
// Top: synchronizes the modem pins, gates transmit starts on clear-to-send
// and forms the modem status interrupt from the change flags.
// Assumes all pins idle high and status_rd is a single-cycle strobe.
module modem_cts_ctl
    import modem_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cts_in,
    input  logic       dcd_in,
    input  logic       dsr_in,
    input  logic       ri_in,
    input  logic       auto_cts_en,
    input  logic       msi_en,
    input  logic       cts_irq_en,
    input  logic [1:0] tx_phase,
    input  logic       byte_ready,
    input  logic       status_rd,
    output logic       start_grant,
    output logic       d_cts,
    output logic       d_dcd,
    output logic       d_dsr,
    output logic       ri_end,
    output logic       irq
);
    logic [MODEM_LINES-1:0] pins;
    logic [MODEM_LINES-1:0] lvl;
    logic [MODEM_LINES-1:0] flags;
    logic                   cts_may_irq;
    logic                   other_evt;

    // Gather the pins in line-index order.
    always_comb begin
        pins          = '1;
        pins[IDX_CTS] = cts_in;
        pins[IDX_DCD] = dcd_in;
        pins[IDX_DSR] = dsr_in;
        pins[IDX_RI]  = ri_in;
    end

    modem_sync #(
        .WIDTH     (MODEM_LINES),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL ('1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pins),
        .q_sync  (lvl)
    );

    modem_delta #(
        .WIDTH  (MODEM_LINES),
        .RI_IDX (IDX_RI)
    ) u_delta (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl       (lvl),
        .status_rd (status_rd),
        .flags     (flags)
    );

    cts_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .cts_lvl    (lvl[IDX_CTS]),
        .auto_en    (auto_cts_en),
        .phase      (tx_phase_e'(tx_phase)),
        .byte_ready (byte_ready),
        .grant      (start_grant)
    );

    assign d_cts  = flags[IDX_CTS];
    assign d_dcd  = flags[IDX_DCD];
    assign d_dsr  = flags[IDX_DSR];
    assign ri_end = flags[IDX_RI];

    // Interrupt: other lines always count; clear-to-send counts unless gating
    // is on without its own enable.
    always_comb begin
        cts_may_irq = !auto_cts_en || cts_irq_en;
        other_evt   = d_dcd || d_dsr || ri_end;
        irq         = msi_en && (other_evt || (d_cts && cts_may_irq));
    end

    // R8: master enable off means no interrupt.
    assert_msi_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !msi_en |-> !irq);
    // R10: clear-to-send alone is silent under gating without its enable.
    assert_cts_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_cts_en && !cts_irq_en && !d_dcd && !d_dsr && !ri_end) |-> !irq);
endmodule

// File: tb/sim_modem_cts_ctl.sv
module sim_modem_cts_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cts_in = 1'b1, dcd_in = 1'b1, dsr_in = 1'b1, ri_in = 1'b1;
    logic       auto_cts_en = 1'b0, msi_en = 1'b0, cts_irq_en = 1'b0;
    logic [1:0] tx_phase = 2'd0;
    logic       byte_ready = 1'b0, status_rd = 1'b0;
    logic       start_grant, d_cts, d_dcd, d_dsr, ri_end, irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    modem_cts_ctl u0 (
        .clk(clk), .rst_n(rst_n),
        .cts_in(cts_in), .dcd_in(dcd_in), .dsr_in(dsr_in), .ri_in(ri_in),
        .auto_cts_en(auto_cts_en), .msi_en(msi_en), .cts_irq_en(cts_irq_en),
        .tx_phase(tx_phase), .byte_ready(byte_ready), .status_rd(status_rd),
        .start_grant(start_grant), .d_cts(d_cts), .d_dcd(d_dcd),
        .d_dsr(d_dsr), .ri_end(ri_end), .irq(irq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic read_status();
        status_rd = 1'b1;
        tick(1);
        status_rd = 1'b0;
    endtask

    task automatic t_reset();
        tick(3);
        check("R1 d_cts", d_cts, 1'b0);
        check("R1 ri_end", ri_end, 1'b0);
        check("R1 irq", irq, 1'b0);
        check("R1 grant", start_grant, 1'b0);
        rst_n = 1'b1;
        tick(4);
        read_status();
        tick(1);
    endtask

    task automatic t_auto_off();
        auto_cts_en = 1'b0;
        cts_in = 1'b1;
        tick(4);
        tx_phase = 2'd0; byte_ready = 1'b1;
        #1 check("R2 grant cts high", start_grant, 1'b1);
        tx_phase = 2'd1;
        #1 check("R12 no grant sending", start_grant, 1'b0);
        tx_phase = 2'd2;
        #1 check("R12 no grant midstop", start_grant, 1'b0);
        tx_phase = 2'd0; byte_ready = 1'b0;
        tick(2);
    endtask

    task automatic t_auto_live();
        auto_cts_en = 1'b1;
        cts_in = 1'b1;
        tick(4);
        byte_ready = 1'b1;
        #1 check("R3 blocked cts high", start_grant, 1'b0);
        tick(1);
        cts_in = 1'b0;
        tick(1);
        check("R3 still blocked in sync", start_grant, 1'b0);
        tick(2);
        check("R3 granted cts low", start_grant, 1'b1);
        byte_ready = 1'b0;
        tick(2);
    endtask

    task automatic t_midstop();
        // Low sample at mid stop, pin rises afterwards: byte still goes.
        auto_cts_en = 1'b1;
        cts_in = 1'b0;
        tx_phase = 2'd1;
        tick(4);
        tx_phase = 2'd2;
        tick(1);
        tx_phase = 2'd1;
        cts_in = 1'b1;
        tick(4);
        tx_phase = 2'd0; byte_ready = 1'b1;
        #1 check("R4 late rise still granted", start_grant, 1'b1);
        tick(1);
        byte_ready = 1'b0;
        tick(1);
        // High sample at mid stop, pin falls just after: held until sync.
        tx_phase = 2'd1;
        tick(2);
        tx_phase = 2'd2;
        tick(1);
        cts_in = 1'b0;
        tx_phase = 2'd0; byte_ready = 1'b1;
        #1 check("R4 blocked by high sample", start_grant, 1'b0);
        tick(1);
        check("R4 blocked during sync", start_grant, 1'b0);
        tick(2);
        check("R4 released after sync", start_grant, 1'b1);
        byte_ready = 1'b0;
        tick(2);
        read_status();
        tick(1);
    endtask

    task automatic t_delta();
        auto_cts_en = 1'b0;
        cts_in = 1'b1;
        tick(2);
        check("R5 no flag before sync", d_cts, 1'b0);
        tick(2);
        check("R5 cts change auto off", d_cts, 1'b1);
        read_status();
        check("R7 cleared", d_cts, 1'b0);
        auto_cts_en = 1'b1;
        cts_in = 1'b0;
        tick(4);
        check("R5 cts change auto on", d_cts, 1'b1);
        read_status();
        dcd_in = 1'b0;
        tick(4);
        check("R6 dcd change", d_dcd, 1'b1);
        dsr_in = 1'b0;
        tick(4);
        check("R6 dsr change", d_dsr, 1'b1);
        ri_in = 1'b0;
        tick(4);
        check("R6 ri fall ignored", ri_end, 1'b0);
        ri_in = 1'b1;
        tick(4);
        check("R6 ri rise flagged", ri_end, 1'b1);
        read_status();
        check("R7 all clear dcd", d_dcd, 1'b0);
        check("R7 all clear ri", ri_end, 1'b0);
    endtask

    task automatic t_irq();
        cts_in = 1'b1;
        tick(4);
        check("R5 flag set for irq test", d_cts, 1'b1);
        msi_en = 1'b0; auto_cts_en = 1'b0;
        #1 check("R8 master off", irq, 1'b0);
        msi_en = 1'b1;
        #1 check("R9 cts irq auto off", irq, 1'b1);
        auto_cts_en = 1'b1; cts_irq_en = 1'b0;
        #1 check("R10 cts masked", irq, 1'b0);
        cts_irq_en = 1'b1;
        #1 check("R11 cts enabled", irq, 1'b1);
        cts_irq_en = 1'b0;
        dcd_in = 1'b1;
        tick(4);
        check("R10 dcd still raises", irq, 1'b1);
        msi_en = 1'b0;
        #1 check("R8 master off with dcd", irq, 1'b0);
        msi_en = 1'b1;
        tick(1);
        read_status();
        check("R7 irq drops after read", irq, 1'b0);
        auto_cts_en = 1'b0;
        ri_in = 1'b0;
        tick(4);
        ri_in = 1'b1;
        tick(4);
        check("R9 ring end raises", irq, 1'b1);
        read_status();
    endtask

    initial begin
        t_reset();
        t_auto_off();
        t_auto_live();
        t_midstop();
        t_delta();
        t_irq();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule